// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in memory. A requester hands over the address, a write flag and a user-mode flag. The block then reads the first-level entry, which sits in the table that the root frame input points at. Unless that entry maps a 4 MB page, the block reads a second-level entry after it. It returns either a physical address or a fault code.

The virtual address splits into three fields. Bits 31:22 index the first-level table, bits 21:12 index the second-level table, and bits 11:0 are the byte offset. Every table holds 1024 entries of 4 bytes each.

Each entry uses this layout:
- bit 0: present
- bit 1: write permitted
- bit 2: user access permitted
- bit 7: large page, used only at the first level
- bits 31:12: frame number

The remaining bits carry attributes that the walker never looks at. A context switch needs nothing more than a new value on the root frame input. The block samples that input when it accepts a request.

Toward memory the block issues word reads through a request/acknowledge handshake. The data comes back on a separate valid strobe.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first read goes to address {root frame, va[31:22], 2'b00}, using the root frame sampled when the request was accepted. A change on `root_frame` during a walk does not affect that walk. The next request uses the new value.
- R3: When the first-level entry is present, permits the access and has bit 7 clear, the second read goes to address {entry[31:12], va[21:12], 2'b00}.
- R4: A successful 4 KB walk responds with `rsp_fault` = 0 and `rsp_paddr` = {second entry[31:12], va[11:0]}.
- R5: A present, permitting first-level entry with bit 7 set ends the walk after one read. It responds with `rsp_fault` = 0 and `rsp_paddr` = {entry[31:22], va[21:0]}.
- R6: An entry whose bit 0 is clear, at either level, ends the walk with `rsp_fault` = 1 (not present) and `rsp_paddr` = 0. When this happens at the first level, no second read is made. The other bits of such an entry are ignored.
- R7: A present entry at either level produces `rsp_fault` = 2 (protection) with `rsp_paddr` = 0 in either of two cases: the request is a write and the entry's bit 1 is 0, or the request is user-mode and the entry's bit 2 is 0. A protection fault at the first level makes no second read.
- R8: At the second level, bit 7 and bits 3–6 and 8–11 have no effect on the translation.
- R9: `req_ready` is 1 only while idle, so no request is accepted during a walk or while a response is pending. A response holds `rsp_valid`, `rsp_paddr` and `rsp_fault` stable until `rsp_ready` is seen.
- R10: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is seen, whatever the number of stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 not present, 2 protection |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The bench goes after the points where a walker most easily goes wrong:
- A large-page entry: a design that missed it would make a needless second read and build the address from the wrong bits.
- Bit 7 set in a second-level entry: a design that honoured it would splice 22 offset bits into the address.
- A non-present entry whose other bits would grant access: this catches a design that checks permissions before presence.
- Write and user denials at each level: a design that checked only one level would return an address where it should fault.
- A root change in the middle of a walk, and memory stalls: these expose a design that reads the root live, and a design that lets the request drop or its address move before the acknowledge.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] root_frame,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_user,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam logic [1:0] F_OK = 2'd0, F_ABSENT = 2'd1, F_PROT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_DIR, S_LEAF, S_RESP} state_t;
  state_t      st;
  logic [31:0] va_q, paddr_q;
  logic [19:0] root_q, tbl_q;
  logic        wr_q, usr_q, sent;
  logic [1:0]  fault_q;

  wire walking = (st == S_DIR) || (st == S_LEAF);
  wire got     = walking && sent && mem_rsp_valid;
  wire present = mem_rsp_data[0];
  wire denied  = (wr_q && !mem_rsp_data[1]) || (usr_q && !mem_rsp_data[2]);
  wire big     = (st == S_DIR) && mem_rsp_data[7];

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign mem_req_valid = walking && !sent;
  assign mem_req_addr  = (st == S_DIR) ? {root_q, va_q[31:22], 2'b00}
                                       : {tbl_q,  va_q[21:12], 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      tbl_q   <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      sent    <= 1'b0;
      paddr_q <= '0;
      fault_q <= F_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          usr_q  <= req_user;
          root_q <= root_frame;
          sent   <= 1'b0;
          st     <= S_DIR;
        end
        S_DIR, S_LEAF: begin
          if (mem_req_valid && mem_req_ready) sent <= 1'b1;
          if (got) begin
            sent <= 1'b0;
            if (!present) begin
              fault_q <= F_ABSENT;
              paddr_q <= '0;
              st      <= S_RESP;
            end else if (denied) begin
              fault_q <= F_PROT;
              paddr_q <= '0;
              st      <= S_RESP;
            end else if (big) begin
              fault_q <= F_OK;
              paddr_q <= {mem_rsp_data[31:22], va_q[21:0]};
              st      <= S_RESP;
            end else if (st == S_DIR) begin
              tbl_q <= mem_rsp_data[31:12];
              st    <= S_LEAF;
            end else begin
              fault_q <= F_OK;
              paddr_q <= {mem_rsp_data[31:12], va_q[11:0]};
              st      <= S_RESP;
            end
          end
        end
        default: if (rsp_ready) st <= S_IDLE;
      endcase
    end
  end

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || mem_req_valid)));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == F_OK |-> rsp_paddr[11:0] == va_q[11:0]);

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != F_OK |-> rsp_paddr == 32'd0);

  p_rsp_data_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
    got |-> !$isunknown(mem_rsp_data));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 0, rst_n = 0;
  logic [19:0] root_frame = 20'h00100;
  logic req_valid = 0, req_write = 0, req_user = 0, rsp_ready = 0;
  logic [31:0] req_vaddr = 0;
  logic req_ready, rsp_valid, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic [1:0] rsp_fault;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [int];
  int rd_cnt = 0, lat = 0, phase = 0, wait_c = 0;
  logic [31:0] rd_addr [0:3];
  logic [31:0] cur_addr;

  pt_walker dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    case (phase)
      0: if (mem_req_valid) begin
        if (wait_c < lat) begin
          if (wait_c > 0) chk("R10 addr stable in stall", mem_req_addr, cur_addr);
          cur_addr = mem_req_addr;
          wait_c++;
        end else begin
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
          cur_addr = mem_req_addr;
          rd_cnt++;
          mem_req_ready = 1;
          phase = 1;
        end
      end
      1: begin
        mem_req_ready = 0;
        mem_rsp_valid = 1;
        mem_rsp_data = mem.exists(int'(cur_addr[31:2])) ? mem[int'(cur_addr[31:2])] : 32'h0;
        phase = 2;
      end
      default: begin
        mem_rsp_valid = 0;
        phase = 0;
        wait_c = 0;
      end
    endcase
  end

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                      input logic [19:0] flip, output logic [31:0] pa,
                      output logic [1:0] f);
    int n;
    @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (flip != 0) root_frame = flip;
    chk("R9 not ready while walking", {31'b0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    pa = rsp_paddr; f = rsp_fault;
    @(negedge clk);
    chk("R9 rsp held valid", {31'b0, rsp_valid}, 32'd1);
    chk("R9 paddr held", rsp_paddr, pa);
    chk("R9 no accept with rsp pending", {31'b0, req_ready}, 32'd0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R9 back to idle", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_small(int l);
    logic [31:0] pa; logic [1:0] f;
    lat = l;
    walk(32'h0040_3ABC, 0, 1, 0, pa, f);
    chk("R2 first read addr", rd_addr[0], 32'h0010_0004);
    chk("R3 second read addr", rd_addr[1], 32'h0020_000C);
    chk("R2 R3 read count", rd_cnt, 2);
    chk("R4 fault ok", {30'b0, f}, 0);
    chk("R4 R8 paddr", pa, 32'h1234_5ABC);
  endtask

  task automatic t_large;
    logic [31:0] pa; logic [1:0] f;
    lat = 1;
    walk(32'h0C12_3456, 1, 1, 0, pa, f);
    chk("R5 read addr", rd_addr[0], 32'h0010_00C0);
    chk("R5 one read", rd_cnt, 1);
    chk("R5 fault ok", {30'b0, f}, 0);
    chk("R5 paddr", pa, 32'h8052_3456);
  endtask

  task automatic t_absent;
    logic [31:0] pa; logic [1:0] f;
    lat = 0;
    walk(32'h0080_0000, 0, 0, 0, pa, f);
    chk("R6 L1 zero fault", {30'b0, f}, 1);
    chk("R6 L1 one read", rd_cnt, 1);
    walk(32'h00C0_0123, 1, 1, 0, pa, f);
    chk("R6 absent beats perms", {30'b0, f}, 1);
    chk("R6 paddr zero", pa, 0);
    chk("R6 one read", rd_cnt, 1);
    walk(32'h0040_4000, 0, 0, 0, pa, f);
    chk("R6 L2 fault", {30'b0, f}, 1);
    chk("R6 L2 two reads", rd_cnt, 2);
  endtask

  task automatic t_prot;
    logic [31:0] pa; logic [1:0] f;
    lat = 2;
    walk(32'h0040_5010, 1, 0, 0, pa, f);
    chk("R7 L2 write denied", {30'b0, f}, 2);
    chk("R7 paddr zero", pa, 0);
    walk(32'h0040_5010, 0, 1, 0, pa, f);
    chk("R7 L2 read allowed", pa, 32'h5555_5010);
    walk(32'h0100_3000, 0, 1, 0, pa, f);
    chk("R7 L1 user denied", {30'b0, f}, 2);
    chk("R7 L1 deny one read", rd_cnt, 1);
    walk(32'h0100_3000, 1, 0, 0, pa, f);
    chk("R7 kernel write ok", {30'b0, f}, 0);
    chk("R7 kernel paddr", pa, 32'h1234_5000);
  endtask

  task automatic t_root;
    logic [31:0] pa; logic [1:0] f;
    lat = 1;
    walk(32'h0040_3ABC, 0, 0, 20'h00180, pa, f);
    chk("R2 root sampled at accept", pa, 32'h1234_5ABC);
    walk(32'h0040_3ABC, 0, 0, 0, pa, f);
    chk("R2 new root first read", rd_addr[0], 32'h0018_0004);
    chk("R2 new root paddr", pa, 32'h6789_AABC);
    root_frame = 20'h00100;
  endtask

  initial begin
    mem[int'(32'h0010_0004 >> 2)] = 32'h0020_0007;
    mem[int'(32'h0020_000C >> 2)] = 32'h1234_5FFF;
    mem[int'(32'h0010_00C0 >> 2)] = 32'h8040_0087;
    mem[int'(32'h0010_000C >> 2)] = 32'h0030_0006;
    mem[int'(32'h0020_0014 >> 2)] = 32'h5555_5005;
    mem[int'(32'h0010_0010 >> 2)] = 32'h0020_0003;
    mem[int'(32'h0018_0004 >> 2)] = 32'h0028_0007;
    mem[int'(32'h0028_000C >> 2)] = 32'h6789_A007;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_small(0);
    t_small(3);
    t_large;
    t_absent;
    t_prot;
    t_root;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule